// File: doc/BRIEF.md
# Timer Match Action Controller

This block is a free-running timer with a programmable prescaler and four compare channels. A prescale counter divides the clock. Each time it reaches its limit, the timer counter advances by one. On that same tick every channel compares its compare value with the timer counter.

A channel that hits carries out the actions enabled in its own three-bit field of the action register. There are three actions:
- latch a sticky interrupt flag,
- load the counter with zero instead of the incremented value,
- halt the timer by clearing the software run-enable bit.

Software reaches every register through a word-addressed write/read port, and a single interrupt line reports any pending flag.

Typical uses are a periodic tick (a compare value with the reset action), a one-shot delay (the stop action), or several timed events within one period (interrupt-only channels).

Top module: `tmr_match_ctrl`

## Requirements
- R1: After reset every register reads 0, the counter is halted and `irq` is low.
- R2: While the run bit (control bit 0) is 1, the prescale count rises by one per clock. On the clock where it equals the prescale limit it returns to 0 and the timer counter increments, so the counter advances once every limit+1 clocks.
- R3: Byte offsets: flags 0x00, control 0x04, timer count 0x08, prescale limit 0x0C, prescale count 0x10, action register 0x14, compare value of channel n at 0x18+4n. In the action register, channel n uses bit 3n for interrupt, bit 3n+1 for counter reset and bit 3n+2 for stop.
- R4: When a channel with its interrupt bit set hits, flag bit n of the flags register is 1 from the next clock on, and `irq` is high while any flag is 1.
- R5: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R6: A hit on a channel with the reset bit loads the timer counter with 0 in place of the incremented value, and counting goes on from 0.
- R7: A hit on a channel with the stop bit clears the run bit. The timer counter keeps the matched value and the prescale count stays at 0. A stop takes priority over a control write in the same clock.
- R8: All channels hitting on the same tick apply all their actions together. Reset plus stop leaves the counter at 0 and halted.
- R9: Compare values are checked only on a prescale tick while running. A hit whose action bits are all 0, or an equal value loaded while halted, changes nothing.
- R10: While control bit 1 is 1, the timer and prescale counters are held at 0.
- R11: A write to the timer count loads it. The prescale count is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register (combinational) |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with its defaults: a 32-bit counter, four channels and an 8-bit address. The full counter width lets random start values near the 32-bit wrap be loaded directly through the timer count register. Prescale limits from 0 to 3 make both every-clock ticks and divided ticks reachable within a few dozen clocks. Random trials cover all eight action combinations on a randomly chosen channel. Directed cases cover simultaneous hits on three channels, hits while halted, the clear-by-one flag rule and the synchronous hold.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Per-channel action field; irq lands on bit 0, clr on bit 1, stop on bit 2
    typedef struct packed {
        logic stop;
        logic clr;
        logic irq;
    } act_t;

    localparam int ACT_W = $bits(act_t);

    // Word indices of the register map (byte offset = 4 * index)
    localparam int IDX_FLAG = 0;
    localparam int IDX_CTRL = 1;
    localparam int IDX_TC   = 2;
    localparam int IDX_PRE  = 3;
    localparam int IDX_PCNT = 4;
    localparam int IDX_ACT  = 5;
    localparam int IDX_MR0  = 6;

    // Control register bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_HOLD = 1;

    function automatic act_t field_of(input logic [ACT_W-1:0] bits);
        return act_t'(bits);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] pcnt,
    output logic             tick
);
    assign tick = run && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_CH  = 4
) (
    input  logic                       tick,
    input  logic [CNT_W-1:0]           tc,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp,
    input  logic [ACT_W*N_CH-1:0]      acts,
    output logic [N_CH-1:0]            flag_set,
    output logic                       any_clr,
    output logic                       any_stop
);
    logic [N_CH-1:0] clr_v;
    logic [N_CH-1:0] stop_v;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        act_t a;
        logic hit;
        assign a            = field_of(acts[ACT_W*ch +: ACT_W]);
        assign hit          = tick && (tc == cmp[ch]);
        assign flag_set[ch] = hit && a.irq;
        assign clr_v[ch]    = hit && a.clr;
        assign stop_v[ch]   = hit && a.stop;
    end

    assign any_clr  = |clr_v;
    assign any_stop = |stop_v;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [CNT_W-1:0]           bus_wdata,
    output logic [CNT_W-1:0]           bus_rdata,
    input  logic [CNT_W-1:0]           tc,
    input  logic [CNT_W-1:0]           pcnt,
    input  logic                       stop_evt,
    input  logic [N_CH-1:0]            flag_set,
    output logic                       run_en,
    output logic                       hold,
    output logic [CNT_W-1:0]           limit,
    output logic [ACT_W*N_CH-1:0]      acts,
    output logic [N_CH-1:0][CNT_W-1:0] cmp,
    output logic [N_CH-1:0]            flags,
    output logic                       tc_load
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int AF_W  = ACT_W * N_CH;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    logic we_flag, we_ctrl, we_pre, we_act;
    assign we_flag = bus_wr && (idx == IDX_W'(IDX_FLAG));
    assign we_ctrl = bus_wr && (idx == IDX_W'(IDX_CTRL));
    assign we_pre  = bus_wr && (idx == IDX_W'(IDX_PRE));
    assign we_act  = bus_wr && (idx == IDX_W'(IDX_ACT));
    assign tc_load = bus_wr && (idx == IDX_W'(IDX_TC));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            hold   <= 1'b0;
        end else begin
            if (we_ctrl) begin
                run_en <= bus_wdata[CTRL_RUN];
                hold   <= bus_wdata[CTRL_HOLD];
            end
            if (stop_evt) begin
                run_en <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
            acts  <= '0;
            flags <= '0;
        end else begin
            if (we_pre) limit <= bus_wdata;
            if (we_act) acts <= bus_wdata[AF_W-1:0];
            flags <= (flags & ~(we_flag ? bus_wdata[N_CH-1:0] : '0)) | flag_set;
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[ch] <= '0;
            end else if (bus_wr && (idx == IDX_W'(IDX_MR0 + ch))) begin
                cmp[ch] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_W'(IDX_FLAG): bus_rdata[N_CH-1:0] = flags;
            IDX_W'(IDX_CTRL): begin
                bus_rdata[CTRL_RUN]  = run_en;
                bus_rdata[CTRL_HOLD] = hold;
            end
            IDX_W'(IDX_TC):   bus_rdata = tc;
            IDX_W'(IDX_PRE):  bus_rdata = limit;
            IDX_W'(IDX_PCNT): bus_rdata = pcnt;
            IDX_W'(IDX_ACT):  bus_rdata[AF_W-1:0] = acts;
            default: begin
                for (int ch = 0; ch < N_CH; ch++) begin
                    if (idx == IDX_W'(IDX_MR0 + ch)) bus_rdata = cmp[ch];
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int AF_W = ACT_W * N_CH;

    logic [CNT_W-1:0]           tc;
    logic [CNT_W-1:0]           pcnt;
    logic [CNT_W-1:0]           limit;
    logic [AF_W-1:0]            acts;
    logic [N_CH-1:0][CNT_W-1:0] cmp;
    logic [N_CH-1:0]            flags;
    logic [N_CH-1:0]            flag_set;
    logic run_en, hold, tick, any_clr, any_stop, tc_load;

    tmr_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tc(tc), .pcnt(pcnt), .stop_evt(any_stop), .flag_set(flag_set),
        .run_en(run_en), .hold(hold), .limit(limit), .acts(acts), .cmp(cmp),
        .flags(flags), .tc_load(tc_load)
    );

    tmr_prescale #(.CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst(rst), .run(run_en && !hold), .hold(hold),
        .limit(limit), .pcnt(pcnt), .tick(tick)
    );

    tmr_match #(.CNT_W(CNT_W), .N_CH(N_CH)) u_match (
        .tick(tick), .tc(tc), .cmp(cmp), .acts(acts),
        .flag_set(flag_set), .any_clr(any_clr), .any_stop(any_stop)
    );

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            tc <= '0;
        end else if (tc_load) begin
            tc <= bus_wdata;
        end else if (tick) begin
            if (any_clr)       tc <= '0;
            else if (!any_stop) tc <= tc + 1'b1;
        end
    end

    assign irq = |flags;
endmodule

// File: rtl/tmr_match_ctrl_chk.sv
module tmr_match_ctrl_chk #(
    parameter int CNT_W = 32,
    parameter int N_CH  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             any_clr,
    input logic             any_stop,
    input logic             tc_load,
    input logic             hold,
    input logic             run_en,
    input logic [CNT_W-1:0] tc,
    input logic [CNT_W-1:0] pcnt,
    input logic [N_CH-1:0]  flag_set,
    input logic             irq
);
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !any_clr && !any_stop && !tc_load) |=> (tc == $past(tc) + 1'b1));

    p_flag_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (|flag_set) |=> irq);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && any_clr && !tc_load) |=> (tc == '0));

    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && any_stop && !any_clr && !tc_load) |=> (tc == $past(tc) && !run_en));

    p_both_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && any_clr && any_stop && !tc_load) |=> (tc == '0 && !run_en));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !tc_load && !hold) |=> $stable(tc));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        hold |=> (tc == '0 && pcnt == '0));
endmodule

bind tmr_match_ctrl tmr_match_ctrl_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) i_chk (
    .clk(clk), .rst(rst), .tick(tick), .any_clr(any_clr), .any_stop(any_stop),
    .tc_load(tc_load), .hold(hold), .run_en(run_en), .tc(tc), .pcnt(pcnt),
    .flag_set(flag_set), .irq(irq)
);

// File: tb/test_tmr_match_ctrl.sv
module test_tmr_match_ctrl;
    localparam int CW = 32;
    localparam int NC = 4;
    localparam int AW = 8;

    localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_TC = 8'h08,
                           A_PRE = 8'h0C, A_PCNT = 8'h10, A_ACT = 8'h14, A_MR0 = 8'h18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tmr_match_ctrl #(.CNT_W(CW), .N_CH(NC), .ADDR_W(AW)) i_tmr_match_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic [31:0] tc;
        logic [31:0] pc;
        logic        en;
        logic        fl;
    } mres_t;

    // Expected state after k clocks of running, one channel with action bits act
    function automatic mres_t model(int p, logic [31:0] s, logic [31:0] m,
                                    logic [2:0] act, int k);
        mres_t r;
        r.tc = s; r.pc = 0; r.en = 1'b1; r.fl = 1'b0;
        for (int i = 0; i < k; i++) begin
            if (r.en) begin
                if (r.pc == 32'(p)) begin
                    r.pc = 0;
                    if (r.tc == m) begin
                        if (act[0]) r.fl = 1'b1;
                        if (act[1]) r.tc = 0;
                        else if (!act[2]) r.tc = r.tc + 1;
                        if (act[2]) r.en = 1'b0;
                    end else begin
                        r.tc = r.tc + 1;
                    end
                end else begin
                    r.pc = r.pc + 1;
                end
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clks(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clean();
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_ACT, 32'h0);
        wr(A_FLAG, 32'hF);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        mres_t e;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_FLAG, v); chk("R1 flags", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_TC, v);   chk("R1 tc", v, 0);
        rd(A_ACT, v);  chk("R1 act", v, 0);
        rd(A_MR0 + 8'd12, v); chk("R1 cmp3", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R3: register map readback
        wr(A_ACT, 32'hFFFF_FABC); rd(A_ACT, v); chk("R3 act field", v, 32'hABC);
        wr(A_MR0 + 8'd8, 32'h1234_5678); rd(A_MR0 + 8'd8, v); chk("R3 cmp2", v, 32'h1234_5678);
        wr(A_PRE, 32'h9); rd(A_PRE, v); chk("R3 limit", v, 32'h9);
        wr(A_ACT, 0); wr(A_MR0 + 8'd8, 0);

        // R11: counter load, prescale count read-only
        wr(A_TC, 32'hDEAD_0001); rd(A_TC, v); chk("R11 tc load", v, 32'hDEAD_0001);
        wr(A_PCNT, 32'h5); rd(A_PCNT, v); chk("R11 pcnt ignored", v, 0);

        // R2: prescale limit 2
        clean();
        wr(A_PRE, 2); wr(A_TC, 0); wr(A_CTRL, 1);
        wait_clks(1);
        rd(A_PCNT, v); chk("R2 pcnt step", v, 1);
        rd(A_TC, v);   chk("R2 tc before tick", v, 0);
        wait_clks(2);
        rd(A_TC, v);   chk("R2 tc after tick", v, 1);
        rd(A_PCNT, v); chk("R2 pcnt wrap", v, 0);

        // R10: hold while running
        wr(A_PRE, 0);
        wr(A_CTRL, 3);
        wait_clks(3);
        rd(A_TC, v);   chk("R10 tc held", v, 0);
        rd(A_PCNT, v); chk("R10 pcnt held", v, 0);
        wr(A_CTRL, 1);
        wait_clks(2);
        rd(A_TC, v);   chk("R10 resume", v, 2);

        // R4 / R5: interrupt on channel 1 (bit 3)
        clean();
        wr(A_PRE, 0); wr(A_TC, 7); wr(A_MR0 + 8'd4, 8); wr(A_ACT, 32'h8);
        wr(A_CTRL, 1);
        wait_clks(4);
        rd(A_FLAG, v); chk("R4 flag1", v, 32'h2);
        chk("R4 irq high", 32'(irq), 1);
        rd(A_TC, v);   chk("R9 irq only keeps counting", v, 11);
        wr(A_FLAG, 32'h0); rd(A_FLAG, v); chk("R5 write 0 keeps", v, 32'h2);
        wr(A_FLAG, 32'h2); rd(A_FLAG, v); chk("R5 write 1 clears", v, 0);
        chk("R5 irq low", 32'(irq), 0);

        // R7: stop on channel 3 (bit 11), limit 1
        clean();
        wr(A_PRE, 1); wr(A_TC, 20); wr(A_MR0 + 8'd12, 21); wr(A_ACT, 32'h800);
        wr(A_CTRL, 1);
        wait_clks(6);
        rd(A_TC, v);   chk("R7 tc kept", v, 21);
        rd(A_PCNT, v); chk("R7 pcnt zero", v, 0);
        rd(A_CTRL, v); chk("R7 run cleared", v, 0);
        rd(A_FLAG, v); chk("R7 no flag", v, 0);

        // R8: ch0 reset, ch2 stop+irq, ch3 irq on same value
        clean();
        wr(A_PRE, 0); wr(A_TC, 10);
        wr(A_MR0, 12); wr(A_MR0 + 8'd8, 12); wr(A_MR0 + 8'd12, 12);
        wr(A_ACT, 32'h002 | 32'h140 | 32'h200);
        wr(A_CTRL, 1);
        wait_clks(5);
        rd(A_TC, v);   chk("R8 tc zero", v, 0);
        rd(A_CTRL, v); chk("R8 halted", v, 0);
        rd(A_FLAG, v); chk("R8 flags 2,3", v, 32'hC);

        // R9: equal value loaded while halted
        clean();
        wr(A_MR0 + 8'd4, 32'h55); wr(A_ACT, 32'hFFF);
        wr(A_TC, 32'h55);
        wait_clks(3);
        rd(A_FLAG, v); chk("R9 no flag halted", v, 0);
        rd(A_TC, v);   chk("R9 tc unchanged", v, 32'h55);
        chk("R9 irq low", 32'(irq), 0);

        // Random trials (R2, R4, R6, R7, R8)
        void'($urandom(32'd20241));
        for (int t = 0; t < 40; t++) begin
            int ch, p, k;
            logic [31:0] s, m;
            logic [2:0] act;
            ch  = $urandom_range(0, NC - 1);
            p   = $urandom_range(0, 3);
            s   = $urandom;
            m   = s + 32'($urandom_range(0, 4));
            act = 3'($urandom_range(0, 7));
            k   = $urandom_range(1, 24);
            clean();
            for (int c = 0; c < NC; c++) wr(A_MR0 + 8'(4 * c), ~m);
            wr(A_PRE, 32'(p)); wr(A_TC, s);
            wr(A_MR0 + 8'(4 * ch), m);
            wr(A_ACT, 32'(act) << (3 * ch));
            wr(A_CTRL, 1);
            e = model(p, s, m, act, k);
            wait_clks(k);
            rd(A_TC, v);   chk("R6 random tc", v, e.tc);
            rd(A_PCNT, v); chk("R2 random pcnt", v, e.pc);
            rd(A_CTRL, v); chk("R7 random run", v, 32'(e.en));
            rd(A_FLAG, v); chk("R4 random flag", v, 32'(e.fl) << ch);
            chk("R4 random irq", 32'(irq), 32'(e.fl));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule